// File: doc/BRIEF.md
# Serial-Loaded Latched Print-Enable Controller

This block is the digital control core of a multi-channel solenoid sink driver. A host clocks channel-select bits into a shift register through a slow serial interface. Data leaves the far end of the register on a cascade output, so several controllers can be chained into one long word. A falling edge on the strobe line copies the shifted word into an output latch. The same edge opens a print-enable window, and during that window the latched channels are driven.

The window closes in one of three ways, chosen by a mode input. In timer mode a 16-bit cycle count ends it. In external-disable mode a rising edge on a disable line ends it. In continuous mode there is no window at all, and the channels simply follow the latch. A high-side control output is active for exactly as long as the window and can be inverted for a P-channel switch. A thermal-fault input and the synchronous reset force every output to its off state.

All serial-side inputs (shift clock, data, strobe, disable) are asynchronous to the system clock. They are synchronised, and their edges are detected afterwards. A strobe that arrives while a window is open reloads the latch and restarts the window.

Top module: `print_enable_ctrl`

## Requirements
- R1: A rising edge of `sh_clk` shifts the sampled `ser_in` into stage 0 and moves every stage one place up. After N shifts, the bit shifted first sits at channel N-1.
- R2: `ser_out` always shows the top stage (N-1). Shifting a second word therefore pushes the first word out in the order it went in, which allows cascading.
- R3: A falling edge of `stb` copies the shift register into the channel latch. A rising edge of `stb` leaves the latch unchanged.
- R4: Shifting without a strobe falling edge never changes the latch or `chan_drv`, including while a window is open.
- R5: In timer mode (`mode_sel`=0, and also 3), `win_active` stays high for exactly `win_len` consecutive cycles after a strobe. A `win_len` of 0 opens no window.
- R6: In external-disable mode (`mode_sel`=1), the window opens on a strobe falling edge and stays open until a rising edge of `dis`.
- R7: In continuous mode (`mode_sel`=2), the window is always open and `chan_drv` follows the latch.
- R8: `chan_drv` equals the latch while `win_active` is high, and is all zero otherwise.
- R9: `hs_ctrl` equals `win_active` XOR `hs_invert`.
- R10: A strobe falling edge during an open window reloads the latch and restarts the window. In timer mode, a second strobe G cycles after the first gives G+`win_len` active cycles in total.
- R11: While `thermal_fault` is high, `chan_drv` is zero, `win_active` is low and `hs_ctrl` sits at its inactive level. Once the fault clears, the outputs resume from the unchanged window and latch state.
- R12: Reset clears the shift register, the latch and the window. Outputs are then off, with `hs_ctrl` equal to `hs_invert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| ser_in | input | 1 | Serial channel data, asynchronous |
| sh_clk | input | 1 | Serial shift clock, asynchronous |
| stb | input | 1 | Strobe; falling edge latches and opens the window |
| dis | input | 1 | External disable; rising edge closes window in mode 1 |
| mode_sel | input | 2 | 0/3 timer, 1 external disable, 2 continuous |
| win_len | input | 16 | Timer window length in system clock cycles |
| hs_invert | input | 1 | Inverts the high-side control polarity |
| thermal_fault | input | 1 | Forces all outputs off while high |
| ser_out | output | 1 | Cascade output, top shift stage |
| chan_drv | output | N | Per-channel drive enables |
| win_active | output | 1 | Print-enable window after fault gating |
| hs_ctrl | output | 1 | High-side driver control |

## Verification
The assertions check these relations on every cycle: the high-side output tracks the window with the selected polarity, channels are dark outside the window, and a thermal fault blanks everything one cycle later. They also check that the latch only moves on a strobe falling edge, that continuous mode holds the window open, and that a disable edge closes it in external-disable mode. Other behaviours need the bench's scenarios to show them. These are the bit ordering through the shift register and out of the cascade pin, the exact length of a timed window, and the extended length after a restarting strobe. The bench sweeps every 9-bit word through the shift-and-latch path.

// File: rtl/pec_pkg.sv
package pec_pkg;
  typedef enum logic [1:0] {
    PEC_TIMER  = 2'd0,
    PEC_EXTDIS = 2'd1,
    PEC_CONT   = 2'd2,
    PEC_RSVD   = 2'd3
  } pec_mode_e;

  localparam int PEC_TIMER_W = 16;
endpackage

// File: rtl/pec_sync.sv
module pec_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  localparam int LAST = STAGES - 1;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      logic              prev;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= '0;
          prev  <= 1'b0;
        end else begin
          if (STAGES > 1) chain <= {chain[STAGES-2:0], din[g]};
          else            chain <= din[g];
          prev <= chain[LAST];
        end
      end
      assign lvl[g]  = chain[LAST];
      assign rise[g] = chain[LAST] & ~prev;
      assign fall[g] = ~chain[LAST] & prev;
    end
  endgenerate
endmodule

// File: rtl/pec_shift.sv
module pec_shift #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  input  logic         load,
  output logic [N-1:0] sr_q,
  output logic [N-1:0] latch_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (shift_en) begin
      if (N > 1) sr_q <= {sr_q[N-2:0], din};
      else       sr_q <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       latch_q <= '0;
    else if (load) latch_q <= sr_q;
  end
endmodule

// File: rtl/pec_window.sv
module pec_window
  import pec_pkg::*;
#(
  parameter int TW = PEC_TIMER_W
) (
  input  logic          clk,
  input  logic          rst,
  input  pec_mode_e     mode,
  input  logic [TW-1:0] win_len,
  input  logic          start,
  input  logic          stop,
  output logic          open_q
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      cnt    <= '0;
    end else begin
      case (mode)
        PEC_CONT: begin
          open_q <= 1'b1;
          cnt    <= '0;
        end
        PEC_EXTDIS: begin
          cnt <= '0;
          if (start)     open_q <= 1'b1;
          else if (stop) open_q <= 1'b0;
        end
        default: begin
          if (start) begin
            cnt    <= win_len;
            open_q <= (win_len != '0);
          end else if (open_q) begin
            if (cnt <= TW'(1)) begin
              open_q <= 1'b0;
              cnt    <= '0;
            end else begin
              cnt <= cnt - TW'(1);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/print_enable_ctrl.sv
module print_enable_ctrl
  import pec_pkg::*;
#(
  parameter int N       = 9,
  parameter int SYNC_ST = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ser_in,
  input  logic                   sh_clk,
  input  logic                   stb,
  input  logic                   dis,
  input  logic [1:0]             mode_sel,
  input  logic [PEC_TIMER_W-1:0] win_len,
  input  logic                   hs_invert,
  input  logic                   thermal_fault,
  output logic                   ser_out,
  output logic [N-1:0]           chan_drv,
  output logic                   win_active,
  output logic                   hs_ctrl
);
  localparam int NSIG = 4;
  localparam int I_DAT = 0;
  localparam int I_CLK = 1;
  localparam int I_STB = 2;
  localparam int I_DIS = 3;

  logic [NSIG-1:0] s_lvl, s_rise, s_fall;
  logic            stb_fall, dis_rise, sh_rise;
  logic [N-1:0]    sr_q, latch_q;
  logic            win_open, live;
  pec_mode_e       mode;

  assign mode = pec_mode_e'(mode_sel);

  pec_sync #(.W(NSIG), .STAGES(SYNC_ST)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({dis, stb, sh_clk, ser_in}),
    .lvl (s_lvl),
    .rise(s_rise),
    .fall(s_fall)
  );

  assign sh_rise  = s_rise[I_CLK];
  assign stb_fall = s_fall[I_STB];
  assign dis_rise = s_rise[I_DIS];

  pec_shift #(.N(N)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_en(sh_rise),
    .din     (s_lvl[I_DAT]),
    .load    (stb_fall),
    .sr_q    (sr_q),
    .latch_q (latch_q)
  );

  pec_window #(.TW(PEC_TIMER_W)) u_win (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .win_len(win_len),
    .start  (stb_fall),
    .stop   (dis_rise),
    .open_q (win_open)
  );

  assign ser_out = sr_q[N-1];
  assign live    = win_open & ~thermal_fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_drv   <= '0;
      win_active <= 1'b0;
      hs_ctrl    <= hs_invert;
    end else begin
      chan_drv   <= live ? latch_q : '0;
      win_active <= live;
      hs_ctrl    <= live ^ hs_invert;
    end
  end
endmodule

// File: rtl/pec_checker.sv
module pec_checker
  import pec_pkg::*;
#(
  parameter int N = 9
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode_sel,
  input logic         hs_invert,
  input logic         thermal_fault,
  input logic [N-1:0] chan_drv,
  input logic         win_active,
  input logic         hs_ctrl,
  input logic         stb_fall,
  input logic         dis_rise,
  input logic         win_open,
  input logic [N-1:0] latch_q
);
  // R9
  hs_polarity_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> hs_ctrl == (win_active ^ $past(hs_invert)));
  // R8
  dark_outside_chk: assert property (@(posedge clk) disable iff (rst)
    !win_active |-> chan_drv == '0);
  // R11
  fault_blank_chk: assert property (@(posedge clk) disable iff (rst)
    thermal_fault |=> (chan_drv == '0) && !win_active);
  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb_fall |=> latch_q == $past(latch_q));
  // R7
  cont_open_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'd2) |=> win_open);
  // R6
  ext_close_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'd1 && dis_rise && !stb_fall) |=> !win_open);
endmodule

bind print_enable_ctrl pec_checker #(.N(N)) u_pec_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_sel     (mode_sel),
  .hs_invert    (hs_invert),
  .thermal_fault(thermal_fault),
  .chan_drv     (chan_drv),
  .win_active   (win_active),
  .hs_ctrl      (hs_ctrl),
  .stb_fall     (stb_fall),
  .dis_rise     (dis_rise),
  .win_open     (win_open),
  .latch_q      (latch_q)
);

// File: tb/print_enable_ctrl_bench.sv
module print_enable_ctrl_bench;
  localparam int N = 9;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ser_in = 1'b0, sh_clk = 1'b0, stb = 1'b1, dis = 1'b0;
  logic [1:0]   mode_sel = 2'd0;
  logic [15:0]  win_len = 16'd0;
  logic         hs_invert = 1'b0, thermal_fault = 1'b0;
  logic         ser_out, win_active, hs_ctrl;
  logic [N-1:0] chan_drv;

  int total = 0, bad = 0, act_cnt = 0, cyc = 0;

  always #4 clk = ~clk;

  print_enable_ctrl #(.N(N)) u_print_enable_ctrl (
    .clk(clk), .rst(rst), .ser_in(ser_in), .sh_clk(sh_clk), .stb(stb), .dis(dis),
    .mode_sel(mode_sel), .win_len(win_len), .hs_invert(hs_invert),
    .thermal_fault(thermal_fault), .ser_out(ser_out), .chan_drv(chan_drv),
    .win_active(win_active), .hs_ctrl(hs_ctrl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_count(input int n);
    repeat (n) begin
      @(negedge clk);
      if (win_active) act_cnt++;
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b; sh_clk = 1'b0; tick(2);
    sh_clk = 1'b1; tick(3);
    sh_clk = 1'b0; tick(3);
  endtask

  task automatic shift_word(input logic [N-1:0] w);
    for (int b = N - 1; b >= 0; b--) shift_bit(w[b]);
  endtask

  task automatic strobe();
    stb = 1'b1; tick(3);
    stb = 1'b0; tick(6);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] prev;
    tick(4);
    rst = 1'b0;
    tick(1);
    // R12 reset state
    chk(chan_drv == '0, "R12 chan_drv", int'(chan_drv), 0);
    chk(!win_active, "R12 win_active", int'(win_active), 0);
    chk(hs_ctrl == 1'b0, "R12 hs_ctrl", int'(hs_ctrl), 0);
    chk(ser_out == 1'b0, "R12 ser_out", int'(ser_out), 0);

    // R1 R2 R3 R7: exhaustive sweep of every word in continuous mode
    mode_sel = 2'd2;
    tick(3);
    prev = '0;
    for (int w = 0; w < (1 << N); w++) begin
      for (int b = N - 1; b >= 0; b--) begin
        chk(ser_out == prev[b], "R2 cascade bit", int'(ser_out), int'(prev[b]));
        shift_bit(w[b]);
      end
      strobe();
      chk(chan_drv == N'(w), "R1 R3 R7 latched word", int'(chan_drv), w);
      chk(win_active, "R7 window open", int'(win_active), 1);
      prev = N'(w);
    end

    // R3 rising strobe edge ignored
    shift_word(9'h0A5);
    stb = 1'b1; tick(8);
    chk(chan_drv == 9'h1FF, "R3 rising edge ignored", int'(chan_drv), 'h1FF);
    stb = 1'b0; tick(6);
    chk(chan_drv == 9'h0A5, "R3 falling edge latches", int'(chan_drv), 'h0A5);

    // R9 inverted polarity in continuous mode
    hs_invert = 1'b1; tick(2);
    chk(hs_ctrl == 1'b0, "R9 inverted active", int'(hs_ctrl), 0);
    hs_invert = 1'b0; tick(2);
    chk(hs_ctrl == 1'b1, "R9 normal active", int'(hs_ctrl), 1);

    // R11 thermal fault
    thermal_fault = 1'b1; tick(3);
    chk(chan_drv == '0, "R11 fault chan_drv", int'(chan_drv), 0);
    chk(!win_active, "R11 fault win_active", int'(win_active), 0);
    chk(hs_ctrl == 1'b0, "R11 fault hs_ctrl", int'(hs_ctrl), 0);
    thermal_fault = 1'b0; tick(3);
    chk(chan_drv == 9'h0A5, "R11 recovery", int'(chan_drv), 'h0A5);

    // R5 timer lengths, including mode 3 and zero length
    mode_sel = 2'd0; tick(4);
    chk(!win_active && chan_drv == '0, "R8 closed window dark", int'(chan_drv), 0);
    for (int k = 0; k < 6; k++) begin
      int lens[6] = '{1, 2, 5, 37, 0, 12};
      mode_sel = (k == 5) ? 2'd3 : 2'd0;
      win_len = 16'(lens[k]);
      stb = 1'b1; tick(3);
      act_cnt = 0;
      stb = 1'b0;
      tick_count(lens[k] + 30);
      chk(act_cnt == lens[k], "R5 window length", act_cnt, lens[k]);
    end

    // R4 shifting during an open window; R8 R9 inside the window
    mode_sel = 2'd0; win_len = 16'd2000;
    shift_word(9'h133);
    strobe();
    chk(chan_drv == 9'h133, "R8 drive inside window", int'(chan_drv), 'h133);
    chk(hs_ctrl == 1'b1, "R9 hs during window", int'(hs_ctrl), 1);
    shift_word(9'h0CC);
    chk(chan_drv == 9'h133, "R4 latch held while shifting", int'(chan_drv), 'h133);

    // R10 restart: gap 10 cycles, length 40 -> 50 active cycles
    tick(2100);
    win_len = 16'd40;
    stb = 1'b1; tick(3);
    act_cnt = 0;
    stb = 1'b0; tick_count(5);
    stb = 1'b1; tick_count(5);
    stb = 1'b0; tick_count(8);
    chk(chan_drv == 9'h0CC, "R10 reload on restart", int'(chan_drv), 'h0CC);
    tick_count(70);
    chk(act_cnt == 50, "R10 restarted length", act_cnt, 50);

    // R6 external disable
    mode_sel = 2'd1; tick(2);
    strobe();
    tick(40);
    chk(win_active, "R6 open until disable", int'(win_active), 1);
    dis = 1'b1; tick(8);
    chk(!win_active, "R6 closed by disable", int'(win_active), 0);
    chk(chan_drv == '0, "R8 dark after disable", int'(chan_drv), 0);
    dis = 1'b0; tick(4);

    // R12 reset mid-operation
    mode_sel = 2'd0; rst = 1'b1; tick(3);
    rst = 1'b0; tick(1);
    chk(ser_out == 1'b0 && chan_drv == '0, "R12 reset clears", int'(chan_drv), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule